// File: doc/BRIEF.md
# Four-Pulse Reply Preamble Detector

This block watches a stream of 8-bit unsigned samples from an ADC running at 16 MHz. It searches them for the four-pulse preamble that opens a 1090 MHz secondary-surveillance reply, using integer arithmetic only. Every accepted sample is pushed into a 128-entry history. Entry 0 always holds the newest sample, and the oldest entry falls off the far end. From that history the block keeps a match score: the energy in four fixed 8-sample pulse windows, compared with the energy in the other 96 entries.

The block has no fixed amplitude threshold. A preamble is reported where the score forms a local maximum, and that maximum must lie above a programmable floor. Because of this, weak replies whose pulses peak at only 50 to 100 counts are still found. Each detection produces a single-cycle start pulse for a downstream data decoder, together with the score of the peak. A programmable hold-off then suppresses further detections, so the decoder is not restarted in the middle of a frame.

The input is a valid/ready stream. The block never applies back-pressure: `sample_ready` is constantly high, so a sample is taken on every clock edge where `sample_valid` is high. Each accepted sample is fully processed within the cycle that accepts it, so at one sample every 62.5 ns no sample is ever dropped. `min_margin` and `holdoff_len` are plain configuration inputs and are expected to stay static while samples flow.

Top module: `preamble_detector`

## Requirements
- R1: `sample_ready` is 1 in every cycle after reset. A sample is accepted only on a clock edge with `sample_valid` high. Cycles with `sample_valid` low, whatever `sample_data` carries, change neither the history nor any later detection or score.
- R2: After each accepted sample, the score is 4*P - T. Here P is the sum of history entries 0-7, 16-23, 56-63 and 72-79, where entry 0 is the newest sample, and T is the sum of all 128 entries. The score is a signed 18-bit value.
- R3: The sample accepted just before the newest one is confirmed as a peak when three conditions hold. Its score is strictly greater than `min_margin`, it is greater than or equal to the score of the sample before it, and it is strictly greater than the score of the newest sample.
- R4: Under continuous input, `preamble_found` is high for exactly one cycle: the cycle after the clock edge that accepts the second sample following the peak sample. It is never high in two consecutive cycles.
- R5: A peak whose score equals `min_margin` exactly is not reported.
- R6: With `holdoff_len` = L, once a peak has been confirmed on sample k, none of the samples k+1 through k+L can confirm another peak. With L = 0 there is no suppression.
- R7: `peak_score` takes the score of the confirmed peak in the same cycle that `preamble_found` is high. It keeps that value until the next detection.
- R8: A synchronous reset clears the history, both window sums, the score history, the hold-off counter, `preamble_found` and `peak_score`.
- R9: With a constant baseline b and four pulses of amplitude A placed exactly on the windows, the peak score is 96*(A-b). A weak reply with A=60 and b=5 is therefore detected with score 5280.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Sample present on `sample_data` |
| sample_ready | output | 1 | Always 1 after reset; the block never stalls the stream |
| sample_data | input | 8 | Unsigned ADC sample |
| min_margin | input | 17 | Floor that a peak score must strictly exceed |
| holdoff_len | input | 16 | Number of samples after a detection during which no new peak is confirmed |
| preamble_found | output | 1 | One-cycle start pulse for the data decoder |
| peak_score | output | 18 | Signed score of the most recent detected peak |

## Verification
Each window sum is updated incrementally, so any defect in the history taps or in the sums persists. A wrong tap or a lost update skews the score for the next 128 samples. It then shows as a missing, extra or late `preamble_found`, or as a wrong `peak_score`, at the latest two edges after the preamble's last pulse sample is accepted. A corrupted hold-off count or score history shows as a detection that should have been suppressed, or as a missing second detection, at the second preamble of a pair. Every stream is compared sample by sample against a score computed directly from the window definition, which exposes such faults at the first cycle where they matter.

// File: rtl/preamble_pkg.sv
package preamble_pkg;

  // Number of pulses in the preamble template.
  localparam int NUM_PULSES = 4;

  // Start of each pulse window, in units of one pulse length,
  // counted from the newest history entry.
  function automatic int pulse_slot(input int idx);
    case (idx)
      0:       return 0;
      1:       return 2;
      2:       return 7;
      default: return 9;
    endcase
  endfunction

endpackage

// File: rtl/preamble_queue.sv
module preamble_queue #(
  parameter int SAMPLE_W = 8,
  parameter int DEPTH    = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] taps [DEPTH]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
    end else if (push) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(taps[0]) && $stable(taps[DEPTH-1]));

  // R2
  shift_order_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> taps[0] == $past(din) && taps[1] == $past(taps[0]));

endmodule

// File: rtl/window_sums.sv
module window_sums
  import preamble_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int DEPTH     = 128,
  parameter int PULSE_LEN = 8,
  parameter int SUM_W     = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic [SAMPLE_W-1:0] din,
  input  logic [SAMPLE_W-1:0] taps [DEPTH],
  output logic [SUM_W-1:0]    pulse_sum,
  output logic [SUM_W-1:0]    total_sum
);

  logic [SAMPLE_W-1:0] enter_smp [NUM_PULSES];
  logic [SAMPLE_W-1:0] leave_smp [NUM_PULSES];
  logic [SUM_W-1:0]    pulse_next;
  logic [SUM_W-1:0]    total_next;

  for (genvar w = 0; w < NUM_PULSES; w++) begin : g_win
    localparam int START = pulse_slot(w) * PULSE_LEN;
    localparam int LAST  = START + PULSE_LEN - 1;
    if (START == 0) begin : g_head
      assign enter_smp[w] = din;
    end else begin : g_inner
      assign enter_smp[w] = taps[START-1];
    end
    assign leave_smp[w] = taps[LAST];
  end

  always_comb begin
    pulse_next = pulse_sum;
    for (int w = 0; w < NUM_PULSES; w++) begin
      pulse_next = pulse_next + SUM_W'(enter_smp[w]) - SUM_W'(leave_smp[w]);
    end
    total_next = total_sum + SUM_W'(din) - SUM_W'(taps[DEPTH-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_sum <= '0;
      total_sum <= '0;
    end else if (push) begin
      pulse_sum <= pulse_next;
      total_sum <= total_next;
    end
  end

  // R2
  sums_order_chk: assert property (@(posedge clk) disable iff (rst)
    total_sum >= pulse_sum);

  // R8
  sums_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> pulse_sum == '0 && total_sum == '0);

endmodule

// File: rtl/peak_picker.sv
module peak_picker #(
  parameter int SCORE_W = 18,
  parameter int HOLD_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic signed [SCORE_W-1:0] score_now,
  input  logic [SCORE_W-2:0]        min_margin,
  input  logic [HOLD_W-1:0]         holdoff_len,
  output logic                      found,
  output logic signed [SCORE_W-1:0] peak_score
);

  logic signed [SCORE_W-1:0] hist1;
  logic signed [SCORE_W-1:0] hist2;
  logic                      eval_q;
  logic [HOLD_W-1:0]         hold_cnt;
  logic signed [SCORE_W-1:0] floor_s;
  logic                      is_peak;

  assign floor_s = $signed({1'b0, min_margin});
  assign is_peak = (hist1 > floor_s) && (hist1 >= hist2) && (hist1 > score_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist1      <= '0;
      hist2      <= '0;
      eval_q     <= 1'b0;
      hold_cnt   <= '0;
      found      <= 1'b0;
      peak_score <= '0;
    end else begin
      if (push) begin
        hist1 <= score_now;
        hist2 <= hist1;
      end
      eval_q <= push;
      found  <= 1'b0;
      if (eval_q) begin
        if (is_peak && hold_cnt == '0) begin
          found      <= 1'b1;
          peak_score <= hist1;
          hold_cnt   <= holdoff_len;
        end else if (hold_cnt != '0) begin
          hold_cnt <= hold_cnt - 1'b1;
        end
      end
    end
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    found |=> !found);

  // R5
  above_floor_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> peak_score > floor_s);

  // R6
  holdoff_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> $past(hold_cnt) == '0);

  // R3
  falling_after_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> $past(hist1) > $past(score_now) && peak_score == $past(hist1));

  // R7
  score_held_chk: assert property (@(posedge clk) disable iff (rst)
    !found |-> $stable(peak_score));

endmodule

// File: rtl/preamble_detector.sv
module preamble_detector
  import preamble_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int DEPTH     = 128,
  parameter int PULSE_LEN = 8,
  parameter int HOLD_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sample_valid,
  output logic                          sample_ready,
  input  logic [SAMPLE_W-1:0]           sample_data,
  input  logic [SAMPLE_W+$clog2(DEPTH)+$clog2(DEPTH/(NUM_PULSES*PULSE_LEN))-1:0] min_margin,
  input  logic [HOLD_W-1:0]             holdoff_len,
  output logic                          preamble_found,
  output logic signed [SAMPLE_W+$clog2(DEPTH)+$clog2(DEPTH/(NUM_PULSES*PULSE_LEN)):0] peak_score
);

  localparam int ON_COUNT = NUM_PULSES * PULSE_LEN;
  localparam int RATIO    = DEPTH / ON_COUNT;
  localparam int SUM_W    = SAMPLE_W + $clog2(DEPTH);
  localparam int SCORE_W  = SUM_W + $clog2(RATIO) + 1;

  logic                      push;
  logic [SAMPLE_W-1:0]       taps [DEPTH];
  logic [SUM_W-1:0]          pulse_sum;
  logic [SUM_W-1:0]          total_sum;
  logic signed [SCORE_W-1:0] score_now;

  assign sample_ready = 1'b1;
  assign push         = sample_valid & sample_ready;

  preamble_queue #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(push), .din(sample_data), .taps(taps)
  );

  window_sums #(
    .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .PULSE_LEN(PULSE_LEN), .SUM_W(SUM_W)
  ) u_sums (
    .clk(clk), .rst(rst), .push(push), .din(sample_data), .taps(taps),
    .pulse_sum(pulse_sum), .total_sum(total_sum)
  );

  assign score_now = $signed(SCORE_W'(pulse_sum) * SCORE_W'(RATIO))
                   - $signed(SCORE_W'(total_sum));

  peak_picker #(.SCORE_W(SCORE_W), .HOLD_W(HOLD_W)) u_peak (
    .clk(clk), .rst(rst), .push(push), .score_now(score_now),
    .min_margin(min_margin), .holdoff_len(holdoff_len),
    .found(preamble_found), .peak_score(peak_score)
  );

  // R1
  always_ready_chk: assert property (@(posedge clk) disable iff (rst)
    sample_ready);

endmodule

// File: tb/preamble_detector_test.sv
module preamble_detector_test;

  localparam int CLK_PERIOD = 10;
  localparam int NMAX = 400;

  logic               clk = 1'b0;
  logic               rst;
  logic               sample_valid;
  logic               sample_ready;
  logic [7:0]         sample_data;
  logic [16:0]        min_margin;
  logic [15:0]        holdoff_len;
  logic               preamble_found;
  logic signed [17:0] peak_score;

  int tests_run = 0;
  int tests_failed = 0;

  int stim [NMAX];
  int shq [128];
  int det_cnt, det_peak_idx, det_score, mism;

  always #(CLK_PERIOD/2) clk = ~clk;

  preamble_detector uut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_ready(sample_ready),
    .sample_data(sample_data), .min_margin(min_margin), .holdoff_len(holdoff_len),
    .preamble_found(preamble_found), .peak_score(peak_score)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sample_valid = 1'b0; sample_data = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill(input int len, input int base);
    for (int i = 0; i < len; i++) stim[i] = base;
  endtask

  // Pulses at offsets 0-7, 16-23, 56-63, 72-79 from 'start'
  task automatic put_preamble(input int start, input int amp);
    for (int i = 0; i < 80; i++)
      if (i < 8 || (i >= 16 && i < 24) || (i >= 56 && i < 64) || i >= 72)
        stim[start+i] = amp;
  endtask

  function automatic int model_score();
    int p = 0;
    int t = 0;
    for (int i = 0; i < 128; i++) begin
      t += shq[i];
      if (i < 8 || (i >= 16 && i < 24) || (i >= 56 && i < 64) || (i >= 72 && i < 80))
        p += shq[i];
    end
    return 4 * p - t;
  endfunction

  task automatic observe(input int m, input bit cmp, input bit exp_f, input int exp_s);
    if (preamble_found) begin
      det_cnt++;
      det_peak_idx = m - 2;
      det_score = peak_score;
    end
    if (cmp && (preamble_found !== exp_f)) mism++;
    if (cmp && exp_f && preamble_found && (peak_score != exp_s)) mism++;
  endtask

  task automatic run_stream(input int len, input int margin, input int hold, input bit gaps);
    int sp1 = 0, sp2 = 0, hm = 0, snew, exp_s = 0;
    bit exp_prev = 0, det;
    for (int i = 0; i < 128; i++) shq[i] = 0;
    det_cnt = 0; det_peak_idx = -1; det_score = 0; mism = 0;
    min_margin = 17'(margin);
    holdoff_len = 16'(hold);
    for (int m = 0; m < len; m++) begin
      if (gaps && (m % 3 == 0)) begin
        @(negedge clk); sample_valid = 1'b0; sample_data = 8'hFF;
        @(posedge clk); #1; observe(m, 0, 0, 0);
      end
      @(negedge clk); sample_valid = 1'b1; sample_data = 8'(stim[m]);
      @(posedge clk); #1;
      observe(m, !gaps, exp_prev, exp_s);
      for (int i = 127; i > 0; i--) shq[i] = shq[i-1];
      shq[0] = stim[m];
      snew = model_score();
      det = (sp1 > margin) && (sp1 >= sp2) && (sp1 > snew) && (hm == 0);
      if (det) begin hm = hold; exp_s = sp1; end
      else if (hm > 0) hm--;
      exp_prev = det;
      sp2 = sp1; sp1 = snew;
    end
    @(negedge clk); sample_valid = 1'b0; sample_data = 8'hAA;
    @(posedge clk); #1; observe(len, !gaps, exp_prev, exp_s);
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1; observe(len + 1 + k, !gaps, 0, 0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(posedge clk); #1;
    check(preamble_found == 1'b0, "R8", "found after reset", preamble_found, 0);
    check(peak_score == 0, "R8", "peak_score after reset", peak_score, 0);
    check(sample_ready == 1'b1, "R1", "ready after reset", sample_ready, 1);
  endtask

  task automatic t_clean();
    do_reset();
    fill(160, 0); put_preamble(20, 200);
    run_stream(160, 15000, 0, 0);
    check(mism == 0, "R2", "stream vs model mismatches", mism, 0);
    check(det_cnt == 1, "R3", "clean preamble detections", det_cnt, 1);
    check(det_peak_idx == 99, "R4", "peak sample index", det_peak_idx, 99);
    check(det_score == 19200, "R2", "clean peak score", det_score, 19200);
    repeat (5) @(posedge clk); #1;
    check(peak_score == 19200, "R7", "peak_score held", peak_score, 19200);
    check(sample_ready == 1'b1, "R1", "ready during stream", sample_ready, 1);
  endtask

  task automatic t_weak();
    do_reset();
    fill(200, 5); put_preamble(60, 60);
    run_stream(200, 3000, 0, 0);
    check(mism == 0, "R9", "weak stream vs model", mism, 0);
    check(det_cnt == 1, "R9", "weak preamble detections", det_cnt, 1);
    check(det_score == 5280, "R9", "weak peak score", det_score, 5280);
  endtask

  task automatic t_floor();
    do_reset();
    fill(160, 0); put_preamble(20, 200);
    run_stream(160, 19200, 0, 0);
    check(det_cnt == 0, "R5", "peak equal to floor", det_cnt, 0);
    check(mism == 0, "R5", "floor stream vs model", mism, 0);
    do_reset();
    run_stream(160, 19199, 0, 0);
    check(det_cnt == 1, "R5", "peak just above floor", det_cnt, 1);
  endtask

  task automatic t_holdoff();
    do_reset();
    fill(320, 0); put_preamble(20, 200); put_preamble(220, 200);
    run_stream(320, 15000, 250, 0);
    check(det_cnt == 1, "R6", "second preamble inside hold-off", det_cnt, 1);
    check(mism == 0, "R6", "hold-off stream vs model", mism, 0);
    do_reset();
    run_stream(320, 15000, 150, 0);
    check(det_cnt == 2, "R6", "second preamble after hold-off", det_cnt, 2);
    check(det_peak_idx == 299, "R6", "second peak index", det_peak_idx, 299);
  endtask

  task automatic t_gaps();
    do_reset();
    fill(160, 0); put_preamble(20, 200);
    run_stream(160, 15000, 0, 1);
    check(det_cnt == 1, "R1", "detections with idle garbage cycles", det_cnt, 1);
    check(det_score == 19200, "R1", "score with idle garbage cycles", det_score, 19200);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests_run++; tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    rst = 1'b1; sample_valid = 1'b0; sample_data = '0;
    min_margin = '0; holdoff_len = '0;
    t_reset();
    t_clean();
    t_weak();
    t_floor();
    t_holdoff();
    t_gaps();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule